// File: doc/BRIEF.md
# Timer slave mode controller

This block is a counter whose clocking is chosen by a 3-bit slave-mode code. The counter is 16 bits wide by default. Depending on the code, the counter runs on every clock, decodes a quadrature pair in one of three ways, restarts on a trigger, runs only while a trigger is high, waits for a trigger to start it, or takes its clock from trigger edges. All inputs share the system clock. The trigger and the two channel inputs first pass through a synchronizer and then an edge detector. The counter wraps against a programmable auto-reload value and gives a one-cycle update pulse on every wrap and every reload.

The trigger can be used as a level or, when `edge_src_i` is set, as a both-edge pulse source. In that case every transition of `trig_i` becomes a one-cycle pulse. Gating on a pulse has no meaning, so that combination is reported on `cfg_err_o` and the counter is held. No data stream passes through the block, so all pins are plain control and status pins with no handshake.

Top module: `tsm_top`

## Requirements
- R1: The software enable is set by a 0-to-1 change of `cen_i` and cleared by a 1-to-0 change. With `mode_i`=000 and the enable set, the counter rises by one on every clock. With the enable clear, it holds.
- R2: A count up from the auto-reload value `arr_i` goes to 0. A count down from 0 goes to `arr_i`. Either wrap raises `upd_o` for exactly one cycle.
- R3: Mode 001 counts only on edges of `ch2_i`. A rise of ch2 while ch1 is high counts up, and while ch1 is low counts down. A fall of ch2 while ch1 is high counts down, and while ch1 is low counts up.
- R4: Mode 010 counts only on edges of `ch1_i`. A rise of ch1 while ch2 is low counts up, and while ch2 is high counts down. A fall of ch1 while ch2 is high counts up, and while ch2 is low counts down.
- R5: Mode 011 counts on edges of either channel, using the rules of R3 and R4. If both channels change in the same cycle, nothing is counted.
- R6: `dir_o` is 1 after a down count and 0 after an up count. It keeps its value when nothing is counted.
- R7: In mode 100, a trigger rise reloads the counter and pulses `upd_o`, even with the enable clear. The reload value is 0 if `dir_o`=0 and `arr_i` if `dir_o`=1. Apart from that, the counter runs as in R1.
- R8: In mode 101, with the enable set, the counter rises by one on every clock while the synchronized trigger is high. While the trigger is low it holds its value and is not cleared.
- R9: In mode 110, a trigger rise sets the enable. The counter then runs as in R1. Further trigger edges do not stop it. Only a 1-to-0 change of `cen_i` clears the enable.
- R10: In mode 111, with the enable set, each trigger rise adds exactly one to the counter. Otherwise the counter holds.
- R11: When `mode_i`=101 and `edge_src_i`=1, `cfg_err_o` is high in the same cycle and the counter does not change.
- R12: `trg_o` pulses for one cycle on each effective trigger rise, but only in modes 100 to 111, never in 000 to 011. With `edge_src_i`=1, both transitions of `trig_i` are effective rises.
- R13: A change on `trig_i`, `ch1_i` or `ch2_i` shows on `cnt_o`, `upd_o` and `trg_o` after the third rising clock edge: two synchronizer stages plus the output register.
- R14: While `rst` is high at a clock edge, the counter, `dir_o`, `upd_o`, `trg_o` and the enable are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cen_i | input | 1 | Software enable; a 0-to-1 change sets it and a 1-to-0 change clears it |
| trig_i | input | 1 | Trigger input |
| ch1_i | input | 1 | Quadrature channel 1 (filtered) |
| ch2_i | input | 1 | Quadrature channel 2 (filtered) |
| edge_src_i | input | 1 | 1: use the trigger as a both-edge pulse source |
| mode_i | input | 3 | Slave-mode code |
| arr_i | input | 16 | Auto-reload value |
| cnt_o | output | 16 | Counter value |
| dir_o | output | 1 | Direction of the last count, 1 = down |
| upd_o | output | 1 | Update pulse on a wrap or a reload |
| trg_o | output | 1 | Trigger-event pulse |
| cfg_err_o | output | 1 | Illegal gated configuration |

## Verification
A stuck or stale synchronizer stage appears at the ports as a counter change one cycle early or late, compared with the three-edge latency. It can also appear as a missing or doubled step when a channel toggles. A wrong quadrature decision shows up on the very next sample as a count in the wrong direction and a wrong `dir_o`. A wrong software-enable state shows within one cycle in mode 000: the counter either keeps running after the clearing change of `cen_i` or never starts. Sequences that cross a wrap in both directions expose a wrong wrap rule through `upd_o` on the same cycle as the wrap.

// File: rtl/tsm_pkg.sv
package tsm_pkg;

  typedef enum logic [2:0] {
    SM_FREE    = 3'b000,
    SM_ENC_CH2 = 3'b001,
    SM_ENC_CH1 = 3'b010,
    SM_ENC_ALL = 3'b011,
    SM_RESTART = 3'b100,
    SM_GATE    = 3'b101,
    SM_START   = 3'b110,
    SM_EXTCLK  = 3'b111
  } sm_mode_e;

  typedef struct packed {
    logic load;
    logic up;
    logic dn;
  } cnt_cmd_t;

endpackage

// File: rtl/tsm_sync.sv
module tsm_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] lvl_o,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  localparam int LAST = STAGES - 1;

  logic [W-1:0] stg_q [STAGES];
  logic [W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
      prev_q <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
      prev_q <= stg_q[LAST];
    end
  end

  genvar g;
  generate
    for (g = 0; g < W; g++) begin : g_edge
      assign lvl_o[g]  = stg_q[LAST][g];
      assign rise_o[g] = stg_q[LAST][g] & ~prev_q[g];
      assign fall_o[g] = ~stg_q[LAST][g] & prev_q[g];
    end
  endgenerate
endmodule

// File: rtl/tsm_quad.sv
module tsm_quad
  import tsm_pkg::*;
(
  input  sm_mode_e mode_i,
  input  logic     a_lvl_i,
  input  logic     a_rise_i,
  input  logic     a_fall_i,
  input  logic     b_lvl_i,
  input  logic     b_rise_i,
  input  logic     b_fall_i,
  output logic     step_o,
  output logic     dn_o
);
  logic a_edge, b_edge, a_dn, b_dn;

  // channel 1 leads channel 2 when counting up
  assign a_edge = a_rise_i | a_fall_i;
  assign b_edge = b_rise_i | b_fall_i;
  assign a_dn   = (a_rise_i & b_lvl_i) | (a_fall_i & ~b_lvl_i);
  assign b_dn   = (b_rise_i & ~a_lvl_i) | (b_fall_i & a_lvl_i);

  always_comb begin
    step_o = 1'b0;
    dn_o   = 1'b0;
    unique case (mode_i)
      SM_ENC_CH2: begin
        step_o = b_edge;
        dn_o   = b_dn;
      end
      SM_ENC_CH1: begin
        step_o = a_edge;
        dn_o   = a_dn;
      end
      SM_ENC_ALL: begin
        step_o = a_edge ^ b_edge;
        dn_o   = a_edge ? a_dn : b_dn;
      end
      default: begin
        step_o = 1'b0;
        dn_o   = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/tsm_ctrl.sv
module tsm_ctrl
  import tsm_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  sm_mode_e mode_i,
  input  logic     cen_i,
  input  logic     edge_src_i,
  input  logic     t_lvl_i,
  input  logic     t_rise_i,
  input  logic     t_fall_i,
  input  logic     q_step_i,
  input  logic     q_dn_i,
  output cnt_cmd_t cmd_o,
  output logic     en_o,
  output logic     trg_o,
  output logic     cfg_err_o,
  output logic     trig_lvl_o,
  output logic     trig_rise_o
);
  logic cen_prev_q, en_q, trg_q;
  logic cen_set, cen_clr, trig_lvl, trig_rise, cfg_err;

  assign cen_set   = cen_i & ~cen_prev_q;
  assign cen_clr   = ~cen_i & cen_prev_q;
  assign trig_rise = edge_src_i ? (t_rise_i | t_fall_i) : t_rise_i;
  assign trig_lvl  = edge_src_i ? (t_rise_i | t_fall_i) : t_lvl_i;
  assign cfg_err   = (mode_i == SM_GATE) && edge_src_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      cen_prev_q <= 1'b0;
      en_q       <= 1'b0;
      trg_q      <= 1'b0;
    end else begin
      cen_prev_q <= cen_i;
      if (cen_set || ((mode_i == SM_START) && trig_rise)) en_q <= 1'b1;
      else if (cen_clr)                                    en_q <= 1'b0;
      trg_q <= mode_i[2] & trig_rise;
    end
  end

  always_comb begin
    cmd_o      = '0;
    cmd_o.load = (mode_i == SM_RESTART) && trig_rise;
    unique case (mode_i)
      SM_FREE, SM_RESTART, SM_START: cmd_o.up = en_q;
      SM_GATE:   cmd_o.up = en_q & trig_lvl & ~cfg_err;
      SM_EXTCLK: cmd_o.up = en_q & trig_rise;
      default: begin
        cmd_o.up = en_q & q_step_i & ~q_dn_i;
        cmd_o.dn = en_q & q_step_i & q_dn_i;
      end
    endcase
  end

  assign en_o        = en_q;
  assign trg_o       = trg_q;
  assign cfg_err_o   = cfg_err;
  assign trig_lvl_o  = trig_lvl;
  assign trig_rise_o = trig_rise;
endmodule

// File: rtl/tsm_counter.sv
module tsm_counter
  import tsm_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  cnt_cmd_t     cmd_i,
  input  logic [W-1:0] arr_i,
  output logic [W-1:0] cnt_o,
  output logic         dir_o,
  output logic         upd_o
);
  localparam logic [W-1:0] CNT_ONE = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] cnt_q;
  logic         dir_q, upd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      dir_q <= 1'b0;
      upd_q <= 1'b0;
    end else begin
      upd_q <= 1'b0;
      if (cmd_i.load) begin
        cnt_q <= dir_q ? arr_i : '0;
        upd_q <= 1'b1;
      end else if (cmd_i.up) begin
        dir_q <= 1'b0;
        if (cnt_q >= arr_i) begin
          cnt_q <= '0;
          upd_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + CNT_ONE;
        end
      end else if (cmd_i.dn) begin
        dir_q <= 1'b1;
        if (cnt_q == '0) begin
          cnt_q <= arr_i;
          upd_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q - CNT_ONE;
        end
      end
    end
  end

  assign cnt_o = cnt_q;
  assign dir_o = dir_q;
  assign upd_o = upd_q;
endmodule

// File: rtl/tsm_top.sv
module tsm_top
  import tsm_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cen_i,
  input  logic             trig_i,
  input  logic             ch1_i,
  input  logic             ch2_i,
  input  logic             edge_src_i,
  input  logic [2:0]       mode_i,
  input  logic [CNT_W-1:0] arr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             dir_o,
  output logic             upd_o,
  output logic             trg_o,
  output logic             cfg_err_o
);
  localparam int N_IN  = 3;
  localparam int IX_TR = 0;
  localparam int IX_C1 = 1;
  localparam int IX_C2 = 2;

  sm_mode_e   mode;
  logic [N_IN-1:0] raw, lvl, rise, fall;
  logic       q_step, q_dn;
  logic       en_q, trig_lvl, trig_rise;
  cnt_cmd_t   cmd;

  assign mode = sm_mode_e'(mode_i);
  assign raw  = {ch2_i, ch1_i, trig_i};

  tsm_sync #(.W(N_IN), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .d_i    (raw),
    .lvl_o  (lvl),
    .rise_o (rise),
    .fall_o (fall)
  );

  tsm_quad u_quad (
    .mode_i   (mode),
    .a_lvl_i  (lvl[IX_C1]),
    .a_rise_i (rise[IX_C1]),
    .a_fall_i (fall[IX_C1]),
    .b_lvl_i  (lvl[IX_C2]),
    .b_rise_i (rise[IX_C2]),
    .b_fall_i (fall[IX_C2]),
    .step_o   (q_step),
    .dn_o     (q_dn)
  );

  tsm_ctrl u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .mode_i      (mode),
    .cen_i       (cen_i),
    .edge_src_i  (edge_src_i),
    .t_lvl_i     (lvl[IX_TR]),
    .t_rise_i    (rise[IX_TR]),
    .t_fall_i    (fall[IX_TR]),
    .q_step_i    (q_step),
    .q_dn_i      (q_dn),
    .cmd_o       (cmd),
    .en_o        (en_q),
    .trg_o       (trg_o),
    .cfg_err_o   (cfg_err_o),
    .trig_lvl_o  (trig_lvl),
    .trig_rise_o (trig_rise)
  );

  tsm_counter #(.W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst   (rst),
    .cmd_i (cmd),
    .arr_i (arr_i),
    .cnt_o (cnt_o),
    .dir_o (dir_o),
    .upd_o (upd_o)
  );
endmodule

// File: rtl/tsm_chk.sv
module tsm_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic [2:0]       mode_i,
  input logic [CNT_W-1:0] arr_i,
  input logic [CNT_W-1:0] cnt_o,
  input logic             dir_o,
  input logic             upd_o,
  input logic             trg_o,
  input logic             cfg_err_o,
  input logic             en_i,
  input logic             gate_i,
  input logic             trig_rise_i
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  AST_FREE_RUN_STEP: assert property (@(posedge clk) disable iff (rst)
    (mode_i == 3'b000 && en_i && cnt_o < arr_i) |=> (cnt_o == $past(cnt_o) + ONE)); // R1

  AST_UP_WRAP_ZERO: assert property (@(posedge clk) disable iff (rst)
    (upd_o && !dir_o) |-> (cnt_o == '0)); // R2

  AST_GATE_LOW_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mode_i == 3'b101 && !gate_i) |=> $stable(cnt_o)); // R8

  AST_START_SETS_EN: assert property (@(posedge clk) disable iff (rst)
    (mode_i == 3'b110 && trig_rise_i) |=> en_i); // R9

  AST_EXTCLK_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mode_i == 3'b111 && !trig_rise_i) |=> $stable(cnt_o)); // R10

  AST_CFG_ERR_HOLD: assert property (@(posedge clk) disable iff (rst)
    cfg_err_o |=> $stable(cnt_o)); // R11

  AST_TRG_SLAVE_ONLY: assert property (@(posedge clk) disable iff (rst)
    trg_o |-> $past(mode_i[2])); // R12
endmodule

bind tsm_top tsm_chk #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .mode_i      (mode_i),
  .arr_i       (arr_i),
  .cnt_o       (cnt_o),
  .dir_o       (dir_o),
  .upd_o       (upd_o),
  .trg_o       (trg_o),
  .cfg_err_o   (cfg_err_o),
  .en_i        (en_q),
  .gate_i      (trig_lvl),
  .trig_rise_i (trig_rise)
);

// File: tb/tb_tsm_top.sv
module tb_tsm_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst, cen_i, trig_i, ch1_i, ch2_i, edge_src_i;
  logic [2:0]  mode_i;
  logic [15:0] arr_i;
  logic [15:0] cnt_o;
  logic        dir_o, upd_o, trg_o, cfg_err_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tsm_top dut (
    .clk(clk), .rst(rst), .cen_i(cen_i), .trig_i(trig_i), .ch1_i(ch1_i),
    .ch2_i(ch2_i), .edge_src_i(edge_src_i), .mode_i(mode_i), .arr_i(arr_i),
    .cnt_o(cnt_o), .dir_o(dir_o), .upd_o(upd_o), .trg_o(trg_o),
    .cfg_err_o(cfg_err_o)
  );

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; cen_i = 1'b0; trig_i = 1'b0; ch1_i = 1'b0; ch2_i = 1'b0;
    edge_src_i = 1'b0; mode_i = 3'b000; arr_i = 16'd100;
    wait_n(2);
    rst = 1'b0;
  endtask

  task automatic set_ch(input logic a, input logic b);
    ch1_i = a; ch2_i = b;
    wait_n(3);
  endtask

  task automatic t_reset_state();
    do_reset();
    mode_i = 3'b000; cen_i = 1'b1;
    wait_n(5);
    rst = 1'b1; cen_i = 1'b0;
    wait_n(2);
    rst = 1'b0;
    wait_n(2);
    chk("R14", "cnt after reset", cnt_o, 0);
    chk("R14", "dir after reset", dir_o, 0);
    chk("R14", "upd after reset", upd_o, 0);
    chk("R14", "trg after reset", trg_o, 0);
  endtask

  task automatic t_free_run();
    do_reset();
    arr_i = 16'd5; mode_i = 3'b000; cen_i = 1'b1;
    wait_n(2);
    chk("R1", "first count", cnt_o, 1);
    wait_n(4);
    chk("R2", "at reload value", cnt_o, 5);
    chk("R2", "no update before wrap", upd_o, 0);
    wait_n(1);
    chk("R2", "up wrap to zero", cnt_o, 0);
    chk("R2", "update on up wrap", upd_o, 1);
    wait_n(1);
    chk("R2", "update one cycle", upd_o, 0);
    cen_i = 1'b0;
    wait_n(1);
    chk("R1", "last count at clear", cnt_o, 2);
    wait_n(3);
    chk("R1", "hold when disabled", cnt_o, 2);
  endtask

  task automatic t_enc_ch2();
    do_reset();
    mode_i = 3'b001; cen_i = 1'b1;
    wait_n(2);
    set_ch(1, 0); chk("R3", "ch1 edge ignored", cnt_o, 0);
    set_ch(1, 1); chk("R3", "ch2 rise ch1 high up", cnt_o, 1);
    chk("R6", "dir up", dir_o, 0);
    set_ch(0, 1); chk("R3", "ch1 fall ignored", cnt_o, 1);
    set_ch(0, 0); chk("R3", "ch2 fall ch1 low up", cnt_o, 2);
    set_ch(0, 1); chk("R3", "ch2 rise ch1 low down", cnt_o, 1);
    chk("R6", "dir down", dir_o, 1);
  endtask

  task automatic t_enc_ch1();
    do_reset();
    arr_i = 16'd5; mode_i = 3'b010; cen_i = 1'b1;
    wait_n(2);
    set_ch(0, 1); chk("R4", "ch2 edge ignored", cnt_o, 0);
    set_ch(1, 1); chk("R4", "ch1 rise ch2 high down wraps", cnt_o, 5);
    chk("R2", "update on down wrap", upd_o, 1);
    chk("R6", "dir down", dir_o, 1);
    set_ch(1, 0); chk("R4", "ch2 fall ignored", cnt_o, 5);
    set_ch(0, 0); chk("R4", "ch1 fall ch2 low down", cnt_o, 4);
  endtask

  task automatic t_enc_both();
    do_reset();
    mode_i = 3'b011; cen_i = 1'b1;
    wait_n(2);
    set_ch(1, 0); chk("R5", "step 1", cnt_o, 1);
    set_ch(1, 1); chk("R5", "step 2", cnt_o, 2);
    set_ch(0, 1); chk("R5", "step 3", cnt_o, 3);
    set_ch(0, 0); chk("R5", "step 4", cnt_o, 4);
    set_ch(1, 1); chk("R5", "both rise ignored", cnt_o, 4);
    set_ch(0, 0); chk("R5", "both fall ignored", cnt_o, 4);
    set_ch(0, 1); chk("R5", "reverse step", cnt_o, 3);
    chk("R6", "dir down after reverse", dir_o, 1);
  endtask

  task automatic t_restart();
    do_reset();
    mode_i = 3'b000; cen_i = 1'b1;
    wait_n(6);
    mode_i = 3'b100; cen_i = 1'b0;
    wait_n(2);
    chk("R7", "held before trigger", cnt_o, 6);
    trig_i = 1'b1;
    wait_n(2);
    chk("R13", "no reload before third edge", cnt_o, 6);
    wait_n(1);
    chk("R7", "reloaded to zero", cnt_o, 0);
    chk("R7", "update on reload", upd_o, 1);
    chk("R12", "trigger event in slave mode", trg_o, 1);
    wait_n(1);
    chk("R12", "trigger event one cycle", trg_o, 0);
    trig_i = 1'b0; mode_i = 3'b000;
    wait_n(3);
    trig_i = 1'b1;
    wait_n(3);
    chk("R12", "no trigger event in mode 000", trg_o, 0);
  endtask

  task automatic t_gated();
    do_reset();
    mode_i = 3'b101; cen_i = 1'b1;
    wait_n(2);
    chk("R8", "no count with gate low", cnt_o, 0);
    trig_i = 1'b1;
    wait_n(2);
    chk("R13", "gate not yet seen", cnt_o, 0);
    wait_n(1);
    chk("R13", "gate seen at third edge", cnt_o, 1);
    wait_n(3);
    chk("R8", "counts while high", cnt_o, 4);
    trig_i = 1'b0;
    wait_n(3);
    chk("R8", "stops after gate falls", cnt_o, 6);
    wait_n(3);
    chk("R8", "holds, not cleared", cnt_o, 6);
    edge_src_i = 1'b1;
    wait_n(1);
    chk("R11", "config error flagged", cfg_err_o, 1);
    trig_i = 1'b1;
    wait_n(3);
    chk("R11", "no count in error", cnt_o, 6);
    chk("R12", "rise is trigger event", trg_o, 1);
    trig_i = 1'b0;
    wait_n(3);
    chk("R12", "fall is trigger event with edge source", trg_o, 1);
    chk("R11", "still no count", cnt_o, 6);
    edge_src_i = 1'b0;
    wait_n(1);
    chk("R11", "error clears", cfg_err_o, 0);
  endtask

  task automatic t_start();
    do_reset();
    mode_i = 3'b110;
    wait_n(2);
    chk("R9", "idle before trigger", cnt_o, 0);
    trig_i = 1'b1;
    wait_n(3);
    chk("R9", "enable set, not counted yet", cnt_o, 0);
    wait_n(1);
    chk("R9", "counting after start", cnt_o, 1);
    trig_i = 1'b0;
    wait_n(3);
    chk("R9", "trigger fall does not stop", cnt_o, 4);
    trig_i = 1'b1;
    wait_n(3);
    chk("R9", "second rise does not stop", cnt_o, 7);
    cen_i = 1'b1;
    wait_n(1);
    cen_i = 1'b0;
    wait_n(1);
    chk("R9", "last count at clear", cnt_o, 9);
    wait_n(2);
    chk("R9", "stopped by software clear", cnt_o, 9);
  endtask

  task automatic t_extclk();
    do_reset();
    mode_i = 3'b111; cen_i = 1'b1;
    wait_n(3);
    chk("R10", "no trigger no count", cnt_o, 0);
    for (int i = 0; i < 3; i++) begin
      trig_i = 1'b1; wait_n(2);
      trig_i = 1'b0; wait_n(2);
    end
    wait_n(3);
    chk("R10", "one count per rise", cnt_o, 3);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL R14 watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; cen_i = 1'b0; trig_i = 1'b0; ch1_i = 1'b0; ch2_i = 1'b0;
    edge_src_i = 1'b0; mode_i = 3'b000; arr_i = 16'd100;
    wait_n(2);
    t_reset_state();
    t_free_run();
    t_enc_ch2();
    t_enc_ch1();
    t_enc_both();
    t_restart();
    t_gated();
    t_start();
    t_extclk();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule